// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block decides how a processor core comes out of reset. While reset is asserted it captures a 4-bit mode code from pins that are shared with other functions. After reset it takes one of three paths. It can copy a fixed block of program words out of byte-wide external memory into program memory. It can wait for a host to fill internal memory, watching the host's writes as they go past. Or it can let the core run at once. In every path the core is kept in hold until its path finishes.

A byte-wide boot reads byte addresses upward from 0. Every three bytes form one 24-bit program word, most significant byte first. The words are written to program memory addresses 0 upward. When the hold is released, the block pulses a done flag and presents the start location on that same cycle: internal address 0 after any boot, or external address 0 for the mode that does not boot. If a bus request is pending when reset is released, nothing starts until that request is dropped.

Top module: `boot_seq_top`

## Requirements
- R1: The mode code is captured only while rst_n is low. Changes on mode_pins after reset release change neither the boot path, nor host_mode, nor the start location.
- R2: mode_pins bits are [3]=D, [2]=C, [1]=B, [0]=A, and D is ignored. CBA=000 selects byte boot with host_mode=0. CBA=100 selects byte boot with host_mode=1. CBA=101 selects host-loaded boot with host_mode=1. CBA=010 selects no boot with host_mode=0 and start_ext=1.
- R3: The reserved codes CBA=001, 011, 110 and 111 give no boot, host_mode=0 and an internal start (start_ext=0).
- R4: Byte boot requests byte addresses 0 to 95 in order. Each request holds byte_rd_req high with byte_addr stable until byte_rd_valid. The block writes program words to addresses 0 to 31 in order, and each word is {byte 3i, byte 3i+1, byte 3i+2}.
- R5: During byte boot, core_hold stays 1 through all 32 program writes and falls on the cycle after the last one. No further byte reads follow.
- R6: In host-loaded boot, core_hold stays 1 until a host write to program address 0 is seen. It falls on the next cycle. Host writes to other addresses have no effect.
- R7: If bus_req is high when reset is released, the block stays idle, with core_hold=1 and no byte reads, until bus_req is low. bus_req changes after the boot path has started are ignored.
- R8: boot_done is a single-cycle pulse on the cycle core_hold falls. On that cycle start_addr=0 and start_ext gives the start memory (1 for external).
- R9: While in reset: core_hold=1, boot_done=0, pm_wr_en=0, byte_rd_req=0.
- R10: Host-loaded and no-boot paths make no byte reads and no program writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; mode pins are captured while low |
| mode_pins | input | 4 | Shared mode-select pins {D,C,B,A} |
| bus_req | input | 1 | External bus request |
| byte_rd_req | output | 1 | Byte read request, held until accepted |
| byte_addr | output | BYTE_AW | Byte memory address |
| byte_rd_valid | input | 1 | Byte read data valid; accepts the request |
| byte_rd_data | input | 8 | Byte read data |
| host_wr_en | input | 1 | Snooped host write to internal program memory |
| host_wr_addr | input | PM_AW | Address of the snooped host write |
| pm_wr_en | output | 1 | Program memory write strobe |
| pm_wr_addr | output | PM_AW | Program memory write address |
| pm_wr_data | output | WORD_W | Program memory write data |
| core_hold | output | 1 | Keeps the core from executing |
| host_mode | output | 1 | Chip configured in host mode |
| boot_done | output | 1 | One-cycle pulse when hold releases |
| start_ext | output | 1 | First fetch from external (1) or internal (0) memory |
| start_addr | output | PM_AW | First fetch address |

## Verification
The bench feeds byte reads both back to back and with stalls, since a loader that advanced its address without a valid byte would skip or repeat bytes and scramble the words. It checks the release cycle against the last program write: a design that released one cycle early would let the core run with word 31 missing. Host boot is probed with a write to a nonzero address and with mode pins changed after reset, which a design that matched any address or sampled the pins late would take as completion. A bus request held across reset release, then raised again mid-boot, checks both the wait and the later immunity to bus_req.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [1:0] {
    BOOT_NONE = 2'd0,
    BOOT_BYTE = 2'd1,
    BOOT_HOST = 2'd2
  } boot_kind_e;

  typedef enum logic [1:0] {
    ST_ARB  = 2'd0,
    ST_BYTE = 2'd1,
    ST_HOST = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;

  typedef struct packed {
    boot_kind_e kind;
    logic       host_mode;
    logic       ext_start;
  } boot_cfg_t;

  // Bit 3 (D) plays no part in the choice of path.
  function automatic boot_cfg_t decode_mode(input logic [MODE_W-1:0] code);
    boot_cfg_t c;
    c.kind      = BOOT_NONE;
    c.host_mode = 1'b0;
    c.ext_start = 1'b0;
    case (code[2:0])
      3'b000: c.kind = BOOT_BYTE;
      3'b010: c.ext_start = 1'b1;
      3'b100: begin c.kind = BOOT_BYTE; c.host_mode = 1'b1; end
      3'b101: begin c.kind = BOOT_HOST; c.host_mode = 1'b1; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch
  import boot_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_pins,
  output boot_cfg_t         cfg
);

  logic [MODE_W-1:0] mode_q;

  // Tracks the pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_pins;
  end

  assign cfg = decode_mode(mode_q);

  // R1: captured code is frozen once reset is gone
  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

endmodule

// File: rtl/boot_host_watch.sv
module boot_host_watch #(
  parameter int PM_AW    = 14,
  parameter int TRIG_ADR = 0
) (
  input  logic             host_wr_en,
  input  logic [PM_AW-1:0] host_wr_addr,
  output logic             hit
);

  localparam logic [PM_AW-1:0] TRIG = PM_AW'(TRIG_ADR);

  assign hit = host_wr_en && (host_wr_addr == TRIG);

endmodule

// File: rtl/boot_byte_loader.sv
module boot_byte_loader #(
  parameter int PM_AW   = 14,
  parameter int BYTE_AW = 22,
  parameter int WORD_W  = 24,
  parameter int NWORDS  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               byte_rd_req,
  output logic [BYTE_AW-1:0] byte_addr,
  input  logic               byte_rd_valid,
  input  logic [7:0]         byte_rd_data,
  output logic               pm_wr_en,
  output logic [PM_AW-1:0]   pm_wr_addr,
  output logic [WORD_W-1:0]  pm_wr_data,
  output logic               done
);

  localparam int BPW     = WORD_W / 8;
  localparam int NBYTES  = NWORDS * BPW;
  localparam int CNT_W   = $clog2(NBYTES + 1);
  localparam int LANE_W  = (BPW > 1) ? $clog2(BPW) : 1;
  localparam int WIDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int SH_W    = WORD_W - 8;

  // Earlier bytes sit high: the first byte read ends up as the MSB.
  function automatic logic [WORD_W-1:0] join_word(input logic [SH_W-1:0] hi,
                                                  input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [SH_W-1:0] shift_in(input logic [SH_W-1:0] hi,
                                               input logic [7:0] b);
    return {hi[SH_W-9:0], b};
  endfunction

  logic              busy;
  logic [CNT_W-1:0]  byte_cnt;
  logic [LANE_W-1:0] lane;
  logic [WIDX_W-1:0] word_idx;
  logic [SH_W-1:0]   shreg;

  logic accept, word_end, last_word;
  assign accept    = busy && byte_rd_valid;
  assign word_end  = (lane == LANE_W'(BPW - 1));
  assign last_word = (word_idx == WIDX_W'(NWORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      byte_cnt   <= '0;
      lane       <= '0;
      word_idx   <= '0;
      shreg      <= '0;
      pm_wr_en   <= 1'b0;
      pm_wr_addr <= '0;
      pm_wr_data <= '0;
      done       <= 1'b0;
    end else begin
      pm_wr_en <= 1'b0;
      done     <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        byte_cnt <= '0;
        lane     <= '0;
        word_idx <= '0;
      end else if (accept) begin
        byte_cnt <= byte_cnt + CNT_W'(1);
        if (word_end) begin
          pm_wr_en   <= 1'b1;
          pm_wr_addr <= PM_AW'(word_idx);
          pm_wr_data <= join_word(shreg, byte_rd_data);
          lane       <= '0;
          word_idx   <= word_idx + WIDX_W'(1);
          if (last_word) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          shreg <= shift_in(shreg, byte_rd_data);
          lane  <= lane + LANE_W'(1);
        end
      end
    end
  end

  assign byte_rd_req = busy;
  assign byte_addr   = BYTE_AW'(byte_cnt);

  // R4: an unanswered request keeps its address
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rd_req && !byte_rd_valid) |=> (byte_rd_req && $stable(byte_addr)));

  // R4: reads never run past the boot image
  a_r4_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd_req |-> (byte_cnt < CNT_W'(NBYTES)));

  // R5: completion coincides with a program write
  a_r5_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pm_wr_en);

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int PM_AW     = 14,
  parameter int BYTE_AW   = 22,
  parameter int WORD_W    = 24,
  parameter int NWORDS    = 32,
  parameter int INT_START = 0,
  parameter int EXT_START = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         mode_pins,
  input  logic               bus_req,
  output logic               byte_rd_req,
  output logic [BYTE_AW-1:0] byte_addr,
  input  logic               byte_rd_valid,
  input  logic [7:0]         byte_rd_data,
  input  logic               host_wr_en,
  input  logic [PM_AW-1:0]   host_wr_addr,
  output logic               pm_wr_en,
  output logic [PM_AW-1:0]   pm_wr_addr,
  output logic [WORD_W-1:0]  pm_wr_data,
  output logic               core_hold,
  output logic               host_mode,
  output logic               boot_done,
  output logic               start_ext,
  output logic [PM_AW-1:0]   start_addr
);

  boot_cfg_t  cfg;
  seq_state_e st, st_nxt;
  logic       ld_start, ld_done, host_hit, release_ev;
  logic       hold_q, done_q, ext_q;
  logic [PM_AW-1:0] addr_q;

  boot_mode_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pins (mode_pins),
    .cfg       (cfg)
  );

  boot_host_watch #(.PM_AW(PM_AW), .TRIG_ADR(INT_START)) u_watch (
    .host_wr_en   (host_wr_en),
    .host_wr_addr (host_wr_addr),
    .hit          (host_hit)
  );

  boot_byte_loader #(
    .PM_AW(PM_AW), .BYTE_AW(BYTE_AW), .WORD_W(WORD_W), .NWORDS(NWORDS)
  ) u_loader (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (ld_start),
    .byte_rd_req   (byte_rd_req),
    .byte_addr     (byte_addr),
    .byte_rd_valid (byte_rd_valid),
    .byte_rd_data  (byte_rd_data),
    .pm_wr_en      (pm_wr_en),
    .pm_wr_addr    (pm_wr_addr),
    .pm_wr_data    (pm_wr_data),
    .done          (ld_done)
  );

  // Path selection happens once, on the first cycle the bus is free.
  always_comb begin
    st_nxt     = st;
    release_ev = 1'b0;
    ld_start   = 1'b0;
    case (st)
      ST_ARB: if (!bus_req) begin
        case (cfg.kind)
          BOOT_BYTE: begin st_nxt = ST_BYTE; ld_start = 1'b1; end
          BOOT_HOST: st_nxt = ST_HOST;
          default:   begin st_nxt = ST_RUN; release_ev = 1'b1; end
        endcase
      end
      ST_BYTE: if (ld_done)  begin st_nxt = ST_RUN; release_ev = 1'b1; end
      ST_HOST: if (host_hit) begin st_nxt = ST_RUN; release_ev = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_ARB;
      hold_q <= 1'b1;
      done_q <= 1'b0;
      ext_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st     <= st_nxt;
      done_q <= release_ev;
      if (release_ev) begin
        hold_q <= 1'b0;
        ext_q  <= cfg.ext_start;
        addr_q <= cfg.ext_start ? PM_AW'(EXT_START) : PM_AW'(INT_START);
      end
    end
  end

  assign core_hold  = hold_q;
  assign boot_done  = done_q;
  assign start_ext  = ext_q;
  assign start_addr = addr_q;
  assign host_mode  = cfg.host_mode;

  // R5: no program write reaches a running core
  a_r5_hold_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    pm_wr_en |-> core_hold);

  // R8: done marks exactly the falling edge of the hold
  a_r8_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (!core_hold && $past(core_hold)));

  // R6: host path stays held without a write to the trigger address
  a_r6_host_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOST && !host_hit) |=> core_hold);

  // R7: a pending bus request keeps the sequencer idle
  a_r7_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARB && bus_req) |=> (st == ST_ARB && !byte_rd_req && core_hold));

endmodule

// File: tb/sim_boot_seq_top.sv
module sim_boot_seq_top;

  localparam int PM_AW = 14;
  localparam int BYTE_AW = 22;
  localparam int WORD_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] mode_pins = 4'b0000;
  logic bus_req = 1'b0;
  logic byte_rd_req;
  logic [BYTE_AW-1:0] byte_addr;
  logic byte_rd_valid = 1'b0;
  logic [7:0] byte_rd_data = 8'h00;
  logic host_wr_en = 1'b0;
  logic [PM_AW-1:0] host_wr_addr = '0;
  logic pm_wr_en;
  logic [PM_AW-1:0] pm_wr_addr;
  logic [WORD_W-1:0] pm_wr_data;
  logic core_hold, host_mode, boot_done, start_ext;
  logic [PM_AW-1:0] start_addr;

  boot_seq_top u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int cyc = 0, wd = 0;
  int wr_cnt, wr_bad, rd_next, rd_bad, done_cnt, done_cyc, last_wr_cyc;
  int hold_at_done, ext_at_done, addr_at_done;
  bit stall_en = 1'b0;

  function automatic logic [7:0] bm(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [23:0] exp_word(input int i);
    return {bm(3 * i), bm(3 * i + 1), bm(3 * i + 2)};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // byte memory model, optionally stalling every third cycle
  always @(negedge clk) begin
    if (rst_n && byte_rd_req && !(stall_en && (cyc % 3 == 1))) begin
      if (int'(byte_addr) != rd_next) rd_bad++;
      byte_rd_valid <= 1'b1;
      byte_rd_data  <= bm(int'(byte_addr));
      rd_next++;
    end else begin
      byte_rd_valid <= 1'b0;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n && pm_wr_en) begin
      if (int'(pm_wr_addr) != wr_cnt || pm_wr_data != exp_word(wr_cnt) || !core_hold)
        wr_bad++;
      wr_cnt++;
      last_wr_cyc = cyc;
    end
    if (rst_n && boot_done) begin
      done_cnt++;
      done_cyc = cyc;
      hold_at_done = int'(core_hold);
      ext_at_done = int'(start_ext);
      addr_at_done = int'(start_addr);
    end
  end

  task automatic do_reset(input logic [3:0] mode, input logic br);
    @(negedge clk);
    rst_n = 1'b0; mode_pins = mode; bus_req = br; host_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    wr_cnt = 0; wr_bad = 0; rd_next = 0; rd_bad = 0; done_cnt = 0;
    done_cyc = -1; last_wr_cyc = -1; hold_at_done = -1; ext_at_done = -1; addr_at_done = -1;
    rst_n = 1'b1;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0; mode_pins = 4'b0000;
    repeat (2) @(negedge clk);
    check("R9 hold in reset", int'(core_hold), 1);
    check("R9 done in reset", int'(boot_done), 0);
    check("R9 pm_wr_en in reset", int'(pm_wr_en), 0);
    check("R9 byte_rd_req in reset", int'(byte_rd_req), 0);
  endtask

  task automatic t_byte(input logic [3:0] mode, input bit stall, input int exp_host);
    stall_en = stall;
    do_reset(mode, 1'b0);
    repeat (4) @(negedge clk);
    mode_pins = ~mode;                   // R1: late pin change
    wait_done();
    repeat (5) @(negedge clk);
    check("R4 word count", wr_cnt, 32);
    check("R4 word content/order", wr_bad, 0);
    check("R4 byte read order", rd_bad, 0);
    check("R5 bytes read", rd_next, 96);
    check("R5 release after last write", done_cyc, last_wr_cyc + 1);
    check("R5 no read after boot", int'(byte_rd_req), 0);
    check("R8 single done pulse", done_cnt, 1);
    check("R8 hold low at done", hold_at_done, 0);
    check("R8 internal start", ext_at_done, 0);
    check("R8 start addr", addr_at_done, 0);
    check("R2 R1 host_mode", int'(host_mode), exp_host);
    stall_en = 1'b0;
  endtask

  task automatic t_host(input logic [3:0] mode);
    do_reset(mode, 1'b0);
    repeat (6) @(negedge clk);
    mode_pins = 4'b0010;                 // R1: would mean no boot
    repeat (6) @(negedge clk);
    check("R6 held waiting", int'(core_hold), 1);
    check("R1 host_mode kept", int'(host_mode), 1);
    host_wr_en = 1'b1; host_wr_addr = 14'd5;
    @(negedge clk);
    host_wr_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 other address ignored", int'(core_hold), 1);
    check("R10 no byte reads", rd_next, 0);
    check("R10 no pm writes", wr_cnt, 0);
    host_wr_en = 1'b1; host_wr_addr = 14'd0;
    @(negedge clk);
    host_wr_en = 1'b0;
    check("R6 release after addr 0", int'(core_hold), 0);
    check("R8 done with release", int'(boot_done), 1);
    check("R8 internal start host", int'(start_ext), 0);
    repeat (3) @(negedge clk);
    check("R8 one pulse host", done_cnt, 1);
  endtask

  task automatic t_noboot(input logic [3:0] mode, input int exp_ext, input string tag);
    do_reset(mode, 1'b0);
    repeat (2) @(negedge clk);
    mode_pins = 4'b0101;                 // R1
    repeat (4) @(negedge clk);
    check({tag, " done at first cycle"}, done_cyc, 1);
    check({tag, " start_ext"}, ext_at_done, exp_ext);
    check({tag, " host_mode"}, int'(host_mode), 0);
    check({tag, " hold released"}, int'(core_hold), 0);
    check("R10 no reads no writes", rd_next + wr_cnt, 0);
  endtask

  task automatic t_busreq;
    do_reset(4'b1000, 1'b1);
    repeat (10) @(negedge clk);
    check("R7 held under bus_req", int'(core_hold), 1);
    check("R7 no reads under bus_req", rd_next, 0);
    check("R7 no done under bus_req", done_cnt, 0);
    bus_req = 1'b0;
    repeat (5) @(negedge clk);
    bus_req = 1'b1;                      // ignored once started
    wait_done();
    repeat (3) @(negedge clk);
    check("R7 boot completes", wr_cnt, 32);
    check("R7 words correct", wr_bad, 0);
    bus_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_byte(4'b1000, 1'b0, 0);
    t_byte(4'b0000, 1'b1, 0);
    t_byte(4'b0100, 1'b0, 1);
    t_byte(4'b1100, 1'b1, 1);
    t_host(4'b0101);
    t_host(4'b1101);
    t_noboot(4'b0010, 1, "R2 no-boot");
    t_noboot(4'b1010, 1, "R2 no-boot D=1");
    t_noboot(4'b0001, 0, "R3 reserved 001");
    t_noboot(4'b1111, 0, "R3 reserved 111");
    t_noboot(4'b0110, 0, "R3 reserved 110");
    t_busreq();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule